// File: doc/BRIEF.md
# Fixed-Latency Output Pipeline with Blanking and Standby

This block sits between a 12-bit converter core and the output pins of a sensor front end. It accepts one conversion word on every rising edge of the sample clock and presents it on the output bus a fixed number of edges later. A mode pin selects one of two latencies: a short one of 9 edges and a long one of 11 edges. In a typical system the long setting is used whenever pre-blanking is in use.

An active-low blank pin is sampled together with each word and travels with it as a one-bit tag. The slot it marks comes out as all zeros after exactly the same latency as the data. A standby pin clears the output word without waiting for any clock edge, and it empties the pipeline. After a latency change, after standby ends, or after reset, the output stays at zero until the first word captured under the new conditions reaches the end of the pipeline.

The stream has no handshake. A word is taken on every edge, and a word leaves on every edge. The consumer has to be ready on every sample clock, so there is no back-pressure and no valid or ready pin.

Top module: `blank_latency_pipe`

## Requirements
- R1: With `lat_long` = 1, a word sampled on `din` at clock edge k appears unchanged on `dout` right after edge k+10 (11 edges counting the sampling edge).
- R2: With `lat_long` = 0, a word sampled at edge k appears unchanged on `dout` right after edge k+8 (9 edges counting the sampling edge).
- R3: A word sampled while `blank_n` = 0 comes out as 12'h000 in its own output slot, at the same latency as data. If `blank_n` goes low before edge k, `dout` is zero from right after edge k+L-1 on, where L is the selected latency. Words sampled with `blank_n` = 1 pass through.
- R4: The blank mark belongs to one word only. A single blanked word between valid words zeroes exactly one output slot, and both neighbours appear intact.
- R5: While `standby` = 1, `dout` is 12'h000 within the same clock cycle, with no edge needed. Every edge sampled with `standby` = 1 discards the words in flight.
- R6: After `standby` returns to 0, `dout` stays zero until the word sampled at the first edge with `standby` = 0 emerges, L edges later counting that edge.
- R7: If `lat_long` sampled at an edge differs from its value at the previous edge, every word in flight is discarded. `dout` stays zero until the word sampled at that edge emerges at the new latency.
- R8: While `rst_n` = 0 (asynchronous, active low), `dout` is 12'h000. After release, the pipeline refills as in R6, with the first edge after release as the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 12 | Conversion word, sampled every rising edge |
| blank_n | input | 1 | Active-low blank mark, sampled with `din` |
| lat_long | input | 1 | 1 selects 11-edge latency, 0 selects 9-edge latency |
| standby | input | 1 | Forces `dout` to zero at once and empties the pipeline |
| dout | output | 12 | Delayed word, or zero when blanked, invalid or in standby |

## Verification
A word or blank mark sampled at edge k is due on `dout` just after edge k+L-1, where L is the latency in force at that edge. Standby is due within the same cycle. After a restart, the zero window lasts until the first word captured after the restart reaches the end. The bench numbers every edge and records the inputs sampled there. From the requirements alone it works out which sample should be at the output and whether that sample is still valid. It compares `dout` one time unit after each edge, once the design has settled, and it also probes `dout` in the middle of a cycle right after standby rises.

// File: rtl/blp_pkg.sv
package blp_pkg;

  // Per-stage side information carried beside each data word
  typedef struct packed {
    logic live;   // stage holds a word captured since the last restart
    logic blank;  // word was marked for blanking at entry
  } slot_tag_t;

endpackage

// File: rtl/blp_restart_ctl.sv
module blp_restart_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_long,
  input  logic standby,
  output logic mode_q,
  output logic flush,
  output logic entry_live
);

  // Latency in force; compared against the pin to detect a change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b1;
    else        mode_q <= lat_long;
  end

  // Any standby edge or latency change discards words in flight
  always_comb begin
    flush      = standby | (lat_long != mode_q);
    entry_live = ~standby;
  end

endmodule

// File: rtl/blp_delay_line.sv
module blp_delay_line
  import blp_pkg::*;
#(
  parameter int W     = 12,
  parameter int LAT_S = 9,
  parameter int LAT_L = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_live,
  input  logic         in_blank,
  input  logic [W-1:0] in_data,
  output slot_tag_t    tap_s_tag,
  output logic [W-1:0] tap_s_data,
  output slot_tag_t    tap_l_tag,
  output logic [W-1:0] tap_l_data
);

  localparam int DEPTH = LAT_L;

  slot_tag_t    tag_q [DEPTH];
  logic [W-1:0] dat_q [DEPTH];
  logic [DEPTH-1:0] live_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      tag_q[0] <= '{live: in_live, blank: in_blank};
      dat_q[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) begin
        tag_q[i].live  <= tag_q[i-1].live & ~flush;
        tag_q[i].blank <= tag_q[i-1].blank;
        dat_q[i]       <= dat_q[i-1];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) live_vec[i] = tag_q[i].live;
  end

  assign tap_s_tag  = tag_q[LAT_S-1];
  assign tap_s_data = dat_q[LAT_S-1];
  assign tap_l_tag  = tag_q[LAT_L-1];
  assign tap_l_data = dat_q[LAT_L-1];

  // R7 / R5: a flush leaves no live word beyond the entry stage
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live_vec[DEPTH-1:1] == '0));

  // R3 / R4: the blank mark moves exactly one stage per edge
  for (genvar g = 1; g < DEPTH; g++) begin : g_chk
    p_blank_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tag_q[g].blank == $past(tag_q[g-1].blank));
  end

endmodule

// File: rtl/blp_tap_select.sv
module blp_tap_select
  import blp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         use_long,
  input  slot_tag_t    s_tag,
  input  logic [W-1:0] s_data,
  input  slot_tag_t    l_tag,
  input  logic [W-1:0] l_data,
  output slot_tag_t    o_tag,
  output logic [W-1:0] o_data
);

  always_comb begin
    if (use_long) begin
      o_tag  = l_tag;
      o_data = l_data;
    end else begin
      o_tag  = s_tag;
      o_data = s_data;
    end
  end

endmodule

// File: rtl/blank_latency_pipe.sv
module blank_latency_pipe
  import blp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LAT_S  = 9,
  parameter int LAT_L  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              blank_n,
  input  logic              lat_long,
  input  logic              standby,
  output logic [DATA_W-1:0] dout
);

  logic mode_q, flush, entry_live;
  slot_tag_t         s_tag, l_tag, o_tag;
  logic [DATA_W-1:0] s_data, l_data, o_data;

  blp_restart_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_long   (lat_long),
    .standby    (standby),
    .mode_q     (mode_q),
    .flush      (flush),
    .entry_live (entry_live)
  );

  blp_delay_line #(.W(DATA_W), .LAT_S(LAT_S), .LAT_L(LAT_L)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_live    (entry_live),
    .in_blank   (~blank_n),
    .in_data    (din),
    .tap_s_tag  (s_tag),
    .tap_s_data (s_data),
    .tap_l_tag  (l_tag),
    .tap_l_data (l_data)
  );

  blp_tap_select #(.W(DATA_W)) u_sel (
    .use_long (mode_q),
    .s_tag    (s_tag),
    .s_data   (s_data),
    .l_tag    (l_tag),
    .l_data   (l_data),
    .o_tag    (o_tag),
    .o_data   (o_data)
  );

  // Standby acts without a clock edge; blank and refill come from the tag
  always_comb begin
    if (standby || !o_tag.live || o_tag.blank) dout = '0;
    else                                       dout = o_data;
  end

  // R7: a latency change seen at an edge leaves the output dark afterwards
  p_mode_change_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_long != mode_q) |=> (dout == '0));

  // R5: an edge in standby leaves nothing live at the selected tap
  p_standby_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !o_tag.live);

endmodule

// File: tb/blank_latency_pipe_bench.sv
module blank_latency_pipe_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] din = '0;
  logic        blank_n = 1'b1;
  logic        lat_long = 1'b1;
  logic        standby = 1'b0;
  logic [11:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  int edge_n = 0;
  int last_r = 0;
  bit first = 1'b1;
  bit prev_sb = 1'b0;
  bit prev_md = 1'b1;
  logic [11:0] hist_d [4096];
  bit          hist_b [4096];

  always #(CLK_P/2) clk = ~clk;

  blank_latency_pipe u_blank_latency_pipe (
    .clk(clk), .rst_n(rst_n), .din(din), .blank_n(blank_n),
    .lat_long(lat_long), .standby(standby), .dout(dout)
  );

  task automatic check(input string req, input logic [11:0] exp);
    n_chk++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected %h (edge %0d)", req, dout, exp, edge_n);
    end
  endtask

  // One clock edge: record sampled inputs, then compare just after it
  task automatic tick(input string req);
    int lat, s;
    logic [11:0] exp;
    @(posedge clk);
    edge_n++;
    if (!rst_n) begin
      first = 1'b1;
    end else begin
      if (!standby && (first || prev_sb || (lat_long != prev_md))) last_r = edge_n;
      first = 1'b0;
      hist_d[edge_n] = din;
      hist_b[edge_n] = !blank_n;
    end
    prev_sb = standby;
    prev_md = lat_long;
    #1;
    lat = lat_long ? 11 : 9;
    s   = edge_n - lat + 1;
    if (!rst_n || standby || first || s < last_r || s < 1 || hist_b[s]) exp = '0;
    else exp = hist_d[s];
    check(req, exp);
    din = 12'((edge_n * 173 + 41) % 4095 + 1);
  endtask

  task automatic t_reset();
    #2; check("R8", 12'h000);
    for (int i = 0; i < 3; i++) tick("R8");
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) tick("R8");
  endtask

  task automatic t_long();
    lat_long = 1'b1;
    for (int i = 0; i < 20; i++) tick("R1");
  endtask

  task automatic t_short();
    lat_long = 1'b0;
    for (int i = 0; i < 20; i++) tick("R2");
  endtask

  task automatic t_blank_run(input bit md);
    lat_long = md;
    for (int i = 0; i < 12; i++) tick("R3");
    blank_n = 1'b0;
    for (int i = 0; i < 6; i++) tick("R3");
    blank_n = 1'b1;
    for (int i = 0; i < 14; i++) tick("R3");
  endtask

  task automatic t_blank_single();
    for (int i = 0; i < 4; i++) begin
      blank_n = 1'b0; tick("R4");
      blank_n = 1'b1; tick("R4"); tick("R4");
    end
    for (int i = 0; i < 12; i++) tick("R4");
  endtask

  task automatic t_standby();
    for (int i = 0; i < 12; i++) tick("R5");
    #2; standby = 1'b1; #1;
    check("R5", 12'h000);
    for (int i = 0; i < 4; i++) tick("R5");
    standby = 1'b0;
    for (int i = 0; i < 14; i++) tick("R6");
  endtask

  task automatic t_mode_switch();
    lat_long = 1'b1;
    for (int i = 0; i < 13; i++) tick("R7");
    lat_long = 1'b0;
    for (int i = 0; i < 12; i++) tick("R7");
    lat_long = 1'b1;
    for (int i = 0; i < 14; i++) tick("R7");
  endtask

  task automatic t_reset_mid();
    #2; rst_n = 1'b0; #1;
    check("R8", 12'h000);
    tick("R8"); tick("R8");
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) tick("R8");
  endtask

  initial begin
    t_reset();
    t_long();
    t_short();
    t_blank_run(1'b1);
    t_blank_run(1'b0);
    t_blank_single();
    t_standby();
    t_mode_switch();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule